// File: doc/BRIEF.md
# Two-Axis Peak Position Locator

This block finds where a neutron struck a two-dimensional scintillation detector that has 128 readout channels along X and 128 along Y. Upstream shapers report channel peak heights as valid-tagged words on a small number of parallel lanes. Each word carries an axis flag, a 7-bit channel index and a 12-bit peak height. A word takes part only when its height is strictly above a programmable lower-level threshold.

The first qualifying word seen while the block is idle opens a fixed gathering window. Every qualifying word that arrives inside that window belongs to the same event. When the window closes, the block spends one cycle judging the event. It reports the strongest X channel and the strongest Y channel as the position, together with a time-of-flight stamp taken when the window opened. The event is dropped instead if too many words qualified, or if either axis saw nothing. Each of the two drop causes has its own counter.

Top module: `pf_xy_locator`

## Requirements
- R1: A lane word qualifies only when its valid bit is 1 and its peak height is strictly greater than `lld_level`. A word equal to or below the threshold opens no window, and it takes no part in position, count or drops.
- R2: A qualifying word in an idle cycle opens a window of `WIN_CYC` (10) cycles, and that trigger cycle counts as cycle 0. Qualifying words in cycles 0 to 9 belong to the event. Cycle 10 is the judge cycle, and words arriving in it are ignored.
- R3: Lane flag `hit_is_y` = 0 marks an X word and 1 marks a Y word. `ev_x` is the channel of the highest X peak in the event, and `ev_y` is the channel of the highest Y peak.
- R4: When two words on the same axis carry equal peaks, the lower channel index wins. This applies within a cycle and across cycles.
- R5: An event with more than `MAX_HITS` (32) qualifying words on both axes together is dropped, and `drop_mult_cnt` increments by one. An event with exactly 32 words is kept. The multiplicity cause takes priority over a missing axis.
- R6: An event that stays within the multiplicity limit but has no X word or no Y word is dropped, and `drop_axis_cnt` increments by one. Each judged event has exactly one outcome.
- R7: An accepted event raises `ev_valid` for exactly one cycle, in cycle 11 after the trigger, with `ev_x`, `ev_y` and `ev_tof` valid in that cycle. A new trigger is taken from that same cycle onward.
- R8: The time-of-flight counter advances by one every cycle and wraps at `TOF_W` bits. It reads 0 in the cycle after a `frame_start` pulse. `ev_tof` is the counter value in the trigger cycle.
- R9: After reset, `ev_valid` is 0 and both drop counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Restarts the time-of-flight counter |
| lld_level | input | 12 | Lower-level threshold for peak heights |
| hit_valid | input | LANES | Per-lane word valid |
| hit_is_y | input | LANES | Per-lane axis flag, 0 = X, 1 = Y |
| hit_chan | input | LANES*7 | Per-lane channel index, lane n at bits [7n+6:7n] |
| hit_peak | input | LANES*12 | Per-lane peak height, lane n at bits [12n+11:12n] |
| ev_valid | output | 1 | One-cycle pulse for an accepted event |
| ev_x | output | 7 | X channel of the accepted event |
| ev_y | output | 7 | Y channel of the accepted event |
| ev_tof | output | TOF_W | Time-of-flight stamp of the accepted event |
| drop_mult_cnt | output | CNT_W | Events dropped for multiplicity |
| drop_axis_cnt | output | CNT_W | Events dropped for a missing axis |

## Verification
The bench aims at the window edges. A word in cycle 9 must join the event and a louder word in cycle 10 must not. A design off by one there would move the position to the late word or start a stray event. Equal-height words test the tie rule, which a design with a reversed comparator fails by reporting the higher channel. Events of 32 and 33 words test the multiplicity limit, and the 33-word event has X words only. A wrong limit drops a valid event, and a wrong priority bumps the missing-axis counter. A trigger placed in the very cycle the previous result appears tests re-arming, which a design that waits an extra cycle would lose.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int CHANNELS = 128;
  localparam int CHAN_W   = $clog2(CHANNELS);
  localparam int PEAK_W   = 12;

  typedef logic [CHAN_W-1:0] chan_t;
  typedef logic [PEAK_W-1:0] peak_t;

  typedef enum logic [1:0] {ST_IDLE, ST_GATHER, ST_JUDGE} phase_e;

  // Qualification against the lower-level threshold (strictly above).
  function automatic logic above_lld(peak_t pk, peak_t lvl);
    return pk > lvl;
  endfunction

  // Candidate a displaces candidate b: louder, or equal and lower channel.
  function automatic logic outranks(peak_t pa, chan_t ca, peak_t pb, chan_t cb);
    return (pa > pb) || ((pa == pb) && (ca < cb));
  endfunction
endpackage

// File: rtl/pf_tof_clock.sv
module pf_tof_clock #(
  parameter int TOF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  output logic [TOF_W-1:0] tof_now
);
  always_ff @(posedge clk) begin
    if (!rst_n)           tof_now <= '0;
    else if (frame_start) tof_now <= '0;
    else                  tof_now <= tof_now + 1'b1;
  end

  p_tof_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_start) && $past(rst_n) |-> tof_now == '0);
endmodule

// File: rtl/pf_axis_peak.sv
module pf_axis_peak
  import pf_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic [LANES-1:0]    take,
  input  chan_t [LANES-1:0]   lane_chan,
  input  peak_t [LANES-1:0]   lane_peak,
  output logic                have,
  output chan_t               best_chan,
  output peak_t               best_peak
);
  logic  c_have;
  chan_t c_chan;
  peak_t c_peak;
  logic  base_have;
  logic  n_have;
  chan_t n_chan;
  peak_t n_peak;

  // Strongest lane of this cycle; lower lane order does not matter, the
  // channel index breaks ties.
  always_comb begin
    c_have = 1'b0;
    c_chan = '0;
    c_peak = '0;
    for (int i = 0; i < LANES; i++) begin
      if (take[i] && (!c_have || outranks(lane_peak[i], lane_chan[i], c_peak, c_chan))) begin
        c_have = 1'b1;
        c_chan = lane_chan[i];
        c_peak = lane_peak[i];
      end
    end
  end

  // Merge the cycle winner with the held winner (discarded on restart).
  always_comb begin
    base_have = restart ? 1'b0 : have;
    n_have    = base_have;
    n_chan    = best_chan;
    n_peak    = best_peak;
    if (c_have && (!base_have || outranks(c_peak, c_chan, best_peak, best_chan))) begin
      n_have = 1'b1;
      n_chan = c_chan;
      n_peak = c_peak;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have      <= 1'b0;
      best_chan <= '0;
      best_peak <= '0;
    end else begin
      have      <= n_have;
      best_chan <= n_chan;
      best_peak <= n_peak;
    end
  end

  // R3: within one event the held peak never falls.
  p_best_monotone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    have && !restart |=> have && (best_peak >= $past(best_peak)));
endmodule

// File: rtl/pf_gather_fsm.sv
module pf_gather_fsm
  import pf_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int WIN_CYC  = 10,
  parameter int MAX_HITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_hit,
  output logic             start,
  output logic             open,
  output logic             judge,
  output logic             too_many
);
  localparam int WC_W = $clog2(WIN_CYC + 1);
  localparam int HC_W = $clog2(LANES * WIN_CYC + 1);

  phase_e          state;
  logic [WC_W-1:0] win_cnt;
  logic [HC_W-1:0] hit_cnt;
  logic [HC_W-1:0] lane_sum;

  assign lane_sum = HC_W'($countones(lane_hit));
  assign start    = (state == ST_IDLE) && (|lane_hit);
  assign open     = start || (state == ST_GATHER);
  assign judge    = (state == ST_JUDGE);
  assign too_many = hit_cnt > HC_W'(MAX_HITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      win_cnt <= '0;
      hit_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= (WIN_CYC > 1) ? ST_GATHER : ST_JUDGE;
          win_cnt <= WC_W'(1);
          hit_cnt <= lane_sum;
        end
        ST_GATHER: begin
          hit_cnt <= hit_cnt + lane_sum;
          win_cnt <= win_cnt + 1'b1;
          if (win_cnt == WC_W'(WIN_CYC - 1)) state <= ST_JUDGE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: judging happens only right after the gathering window.
  p_judge_after_gather_r2: assert property (@(posedge clk) disable iff (!rst_n)
    judge |-> $past(state) == ST_GATHER);
  // R7: the cycle after judging is idle and may trigger again.
  p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    judge |=> state == ST_IDLE);
endmodule

// File: rtl/pf_xy_locator.sv
module pf_xy_locator
  import pf_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int WIN_CYC  = 10,
  parameter int MAX_HITS = 32,
  parameter int TOF_W    = 16,
  parameter int CNT_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_start,
  input  logic [pf_pkg::PEAK_W-1:0] lld_level,
  input  logic [LANES-1:0]          hit_valid,
  input  logic [LANES-1:0]          hit_is_y,
  input  logic [LANES*pf_pkg::CHAN_W-1:0] hit_chan,
  input  logic [LANES*pf_pkg::PEAK_W-1:0] hit_peak,
  output logic                      ev_valid,
  output logic [pf_pkg::CHAN_W-1:0] ev_x,
  output logic [pf_pkg::CHAN_W-1:0] ev_y,
  output logic [TOF_W-1:0]          ev_tof,
  output logic [CNT_W-1:0]          drop_mult_cnt,
  output logic [CNT_W-1:0]          drop_axis_cnt
);
  chan_t [LANES-1:0]          lane_chan;
  peak_t [LANES-1:0]          lane_peak;
  logic  [LANES-1:0]          lane_hit;
  logic  [1:0][LANES-1:0]     axis_take;
  logic  [1:0]                axis_have;
  chan_t [1:0]                axis_chan;
  peak_t [1:0]                axis_peak;

  logic start, open, judge, too_many;
  logic [TOF_W-1:0] tof_now, tof_hold;
  logic ev_fire, mult_drop, axis_drop;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_chan[g] = hit_chan[g*CHAN_W +: CHAN_W];
    assign lane_peak[g] = hit_peak[g*PEAK_W +: PEAK_W];
    assign lane_hit[g]  = hit_valid[g] && above_lld(lane_peak[g], lld_level);
  end

  assign axis_take[0] = lane_hit & ~hit_is_y & {LANES{open}};
  assign axis_take[1] = lane_hit &  hit_is_y & {LANES{open}};

  pf_gather_fsm #(.LANES(LANES), .WIN_CYC(WIN_CYC), .MAX_HITS(MAX_HITS)) i_fsm (
    .clk(clk), .rst_n(rst_n), .lane_hit(lane_hit),
    .start(start), .open(open), .judge(judge), .too_many(too_many)
  );

  for (genvar a = 0; a < 2; a++) begin : g_axis
    pf_axis_peak #(.LANES(LANES)) i_axis (
      .clk(clk), .rst_n(rst_n), .restart(start), .take(axis_take[a]),
      .lane_chan(lane_chan), .lane_peak(lane_peak),
      .have(axis_have[a]), .best_chan(axis_chan[a]), .best_peak(axis_peak[a])
    );
  end

  pf_tof_clock #(.TOF_W(TOF_W)) i_tof (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .tof_now(tof_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     tof_hold <= '0;
    else if (start) tof_hold <= tof_now;
  end

  assign mult_drop = judge && too_many;
  assign axis_drop = judge && !too_many && !(&axis_have);
  assign ev_fire   = judge && !too_many && (&axis_have);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid      <= 1'b0;
      ev_x          <= '0;
      ev_y          <= '0;
      ev_tof        <= '0;
      drop_mult_cnt <= '0;
      drop_axis_cnt <= '0;
    end else begin
      ev_valid <= ev_fire;
      if (ev_fire) begin
        ev_x   <= axis_chan[0];
        ev_y   <= axis_chan[1];
        ev_tof <= tof_hold;
      end
      if (mult_drop) drop_mult_cnt <= drop_mult_cnt + 1'b1;
      if (axis_drop) drop_axis_cnt <= drop_axis_cnt + 1'b1;
    end
  end

  // R6: one outcome per judged event.
  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    judge |-> $onehot({ev_fire, mult_drop, axis_drop}));
  // R7: an accepted event is a single-cycle pulse.
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> !ev_valid);
  // R5: the multiplicity counter moves only out of a judge cycle.
  p_mult_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && (drop_mult_cnt != $past(drop_mult_cnt)) |-> $past(judge));
  // R6: the missing-axis counter moves only out of a judge cycle.
  p_axis_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && (drop_axis_cnt != $past(drop_axis_cnt)) |-> $past(judge));
endmodule

// File: tb/test_pf_xy_locator.sv
module test_pf_xy_locator;
  localparam int LANES = 4;
  localparam int WIN   = 10;
  localparam int MAXH  = 32;
  localparam int TOFW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 1'b0;
  logic [11:0] lld = 12'd100;
  logic [LANES-1:0] hv = '0, hy = '0;
  logic [LANES*7-1:0] hc = '0;
  logic [LANES*12-1:0] hp = '0;
  logic ev_valid;
  logic [6:0] ev_x, ev_y;
  logic [TOFW-1:0] ev_tof;
  logic [15:0] dmc, dac;

  int checks = 0, fails = 0;
  int evcount = 0, last_x = -1, last_y = -1, last_tof = -1;

  always #2.5 clk = ~clk;

  pf_xy_locator i_pf_xy_locator (
    .clk(clk), .rst_n(rst_n), .frame_start(fs), .lld_level(lld),
    .hit_valid(hv), .hit_is_y(hy), .hit_chan(hc), .hit_peak(hp),
    .ev_valid(ev_valid), .ev_x(ev_x), .ev_y(ev_y), .ev_tof(ev_tof),
    .drop_mult_cnt(dmc), .drop_axis_cnt(dac)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int qa[$], qc[$], qp[$];
  int mphase = 0, tofc = 0, mtof = 0;
  int m_valid = 0, m_x = 0, m_y = 0, m_tof = 0, m_dm = 0, m_da = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mphase = 0; tofc = 0; m_valid = 0; m_dm = 0; m_da = 0;
    end else begin
      int any;
      m_valid = 0;
      any = 0;
      for (int i = 0; i < LANES; i++)
        if (hv[i] && hp[i*12 +: 12] > lld) any = 1;
      if (mphase == 0 && any) begin
        qa.delete(); qc.delete(); qp.delete();
        mtof = tofc;
      end
      if ((mphase == 0 && any) || (mphase >= 1 && mphase < WIN)) begin
        for (int i = 0; i < LANES; i++)
          if (hv[i] && hp[i*12 +: 12] > lld) begin
            qa.push_back(hy[i]); qc.push_back(hc[i*7 +: 7]); qp.push_back(hp[i*12 +: 12]);
          end
        mphase = mphase + 1;
      end else if (mphase == WIN) begin
        if (qa.size() > MAXH) m_dm++;
        else begin
          int bc[2], bp[2];
          bc[0] = -1; bc[1] = -1; bp[0] = -1; bp[1] = -1;
          foreach (qa[j]) begin
            int ax;
            ax = qa[j];
            if (bc[ax] < 0 || qp[j] > bp[ax] || (qp[j] == bp[ax] && qc[j] < bc[ax])) begin
              bc[ax] = qc[j]; bp[ax] = qp[j];
            end
          end
          if (bc[0] < 0 || bc[1] < 0) m_da++;
          else begin m_valid = 1; m_x = bc[0]; m_y = bc[1]; m_tof = mtof; end
        end
        mphase = 0;
      end
      tofc = fs ? 0 : ((tofc + 1) % (1 << TOFW));
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(ev_valid == m_valid, "R2 ev_valid", ev_valid, m_valid);
      if (m_valid) begin
        chk(ev_x == m_x, "R3 ev_x", ev_x, m_x);
        chk(ev_y == m_y, "R3 ev_y", ev_y, m_y);
        chk(ev_tof == m_tof, "R8 ev_tof", ev_tof, m_tof);
      end
      chk(dmc == m_dm, "R5 drop_mult_cnt", dmc, m_dm);
      chk(dac == m_da, "R6 drop_axis_cnt", dac, m_da);
      if (ev_valid) begin
        evcount++; last_x = ev_x; last_y = ev_y; last_tof = ev_tof;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic clr();
    hv = '0; hy = '0; hc = '0; hp = '0; fs = 1'b0;
  endtask
  task automatic put(input int lane, input bit y, input int ch, input int pk);
    hv[lane] = 1'b1; hy[lane] = y; hc[lane*7 +: 7] = 7'(ch); hp[lane*12 +: 12] = 12'(pk);
  endtask
  task automatic tick();
    @(negedge clk); clr();
  endtask
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    #(5ns * 20000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int e0, d0;
    clr();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(ev_valid == 1'b0, "R9 ev_valid", ev_valid, 0);
    chk(dmc == 0, "R9 drop_mult_cnt", dmc, 0);
    chk(dac == 0, "R9 drop_axis_cnt", dac, 0);

    // R1: words at the threshold start nothing
    put(0, 0, 5, 100); put(1, 1, 6, 100); tick();
    put(2, 0, 7, 50); tick();
    idle(15);
    chk(evcount == 0, "R1 events", evcount, 0);
    chk(dmc == 0 && dac == 0, "R1 drops", dmc + dac, 0);

    // R3: highest peak per axis across cycles and lanes
    put(0, 0, 5, 300); put(1, 1, 9, 200); tick();
    put(2, 0, 20, 500); put(3, 1, 3, 250); tick();
    put(0, 0, 7, 400); put(1, 1, 8, 100); tick();
    idle(12);
    chk(evcount == 1, "R3 events", evcount, 1);
    chk(last_x == 20, "R3 x", last_x, 20);
    chk(last_y == 3, "R3 y", last_y, 3);

    // R4: equal peaks, lower channel wins (same cycle and across cycles)
    put(0, 0, 40, 300); put(1, 0, 12, 300); put(2, 1, 100, 222); tick();
    put(0, 1, 50, 222); put(1, 0, 30, 300); tick();
    idle(12);
    chk(last_x == 12, "R4 x", last_x, 12);
    chk(last_y == 50, "R4 y", last_y, 50);

    // R2: cycle 9 joins, cycle 10 ignored
    e0 = evcount;
    put(0, 0, 1, 200); tick();
    idle(8);
    put(0, 1, 2, 150); tick();
    put(0, 0, 3, 900); put(1, 1, 4, 900); tick();
    idle(15);
    chk(evcount == e0 + 1, "R2 events", evcount, e0 + 1);
    chk(last_x == 1, "R2 x", last_x, 1);
    chk(last_y == 2, "R2 y", last_y, 2);

    // R7: trigger in the cycle the result appears
    e0 = evcount;
    put(0, 0, 10, 300); put(1, 1, 11, 300); tick();
    idle(10);
    chk(ev_valid == 1'b1, "R7 pulse cycle", ev_valid, 1);
    put(0, 0, 60, 700); put(1, 1, 61, 700); tick();
    idle(14);
    chk(evcount == e0 + 2, "R7 events", evcount, e0 + 2);
    chk(last_x == 60 && last_y == 61, "R7 position", last_x * 128 + last_y, 60 * 128 + 61);

    // R5: exactly 32 kept
    e0 = evcount; d0 = dmc;
    for (int c = 0; c < 8; c++) begin
      for (int l = 0; l < 4; l++) put(l, l >= 2, c * 4 + l, 200 + ((c * 4 + l) * 37) % 50);
      tick();
    end
    idle(6);
    chk(evcount == e0 + 1, "R5 32 kept", evcount, e0 + 1);
    chk(dmc == d0, "R5 32 no drop", dmc, d0);
    // R5: 33 X-only dropped for multiplicity, not for missing axis
    d0 = dac;
    for (int c = 0; c < 8; c++) begin
      for (int l = 0; l < 4; l++) put(l, 0, c * 4 + l, 300);
      tick();
    end
    put(0, 0, 99, 300); tick();
    idle(6);
    chk(dmc == 1, "R5 33 dropped", dmc, 1);
    chk(dac == d0, "R5 priority", dac, d0);

    // R6: Y-only event dropped for missing axis
    put(0, 1, 70, 800); put(1, 1, 71, 900); tick();
    idle(12);
    chk(dac == d0 + 1, "R6 missing X", dac, d0 + 1);

    // R8: time of flight after frame restart
    fs = 1'b1; @(negedge clk); clr();
    idle(4);
    put(0, 0, 33, 400); put(1, 1, 44, 400); tick();
    idle(12);
    chk(last_tof == 4, "R8 tof", last_tof, 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule